// File: doc/BRIEF.md
# Clock-Sweep Replacement Frame Picker

This block holds a per-frame table for a demand-paged memory system and picks which physical frame to evict when a page fault needs room. Each frame records the page number that lives in it, a recently-used mark and a modified flag. Access notifications from the translation path set the mark on every touch and the modified flag on writes. An install port loads a new page into a frame once the fault has been served.

When a fault asks for a victim, a hand pointer walks the frames one per clock, starting from where it last stopped. Marked frames get their marks cleared as the hand passes. Modified frames are handed out once each as write-back requests on a valid/ready port. The walk ends at the first frame that is neither marked nor modified, and that frame's number and resident page are reported with a one-cycle done pulse. If no such frame exists, the hand keeps circling until a write-back completes. A modified frame is never chosen.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset the hand is at frame 0, every frame is unmarked and unmodified, `busy`, `done` and `wb_valid` are low, so the first search selects frame 0.
- R2: An access to a frame sets its mark; an access with `acc_write` high also sets its modified flag.
- R3: An install writes the page number into the frame, sets its mark and clears its modified flag and any outstanding write-back for it.
- R4: The hand moves only during a search; a search starts on `fault_req` while `busy` is low and examines one frame per clock, advancing from the last frame number back to 0.
- R5: A marked frame the hand examines has its mark cleared and is not selected.
- R6: A modified frame the hand examines with no write-back outstanding raises `wb_valid` with its number on `wb_frame`; the hand holds there until `wb_ready` is high, and that frame is not requested again until its clean notification arrives.
- R7: `clean_valid` with a frame number clears that frame's modified flag and outstanding write-back.
- R8: The search stops at the first frame that is unmarked and unmodified; two clocks after the deciding edge `done` pulses for one cycle with `victim_frame` and `victim_page` showing that frame and its page, and the hand stays on it.
- R9: When every frame is marked and clean, the search clears them all, wraps, and selects the frame it started from.
- R10: While no frame is unmarked and unmodified, the search keeps circling with `busy` high and never asserts `done`.
- R11: An access that sets a frame's mark in the same cycle the hand clears it leaves the mark set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access notification strobe |
| acc_frame | input | FRAME_W | Frame accessed |
| acc_write | input | 1 | Access is a write |
| inst_valid | input | 1 | Install strobe |
| inst_frame | input | FRAME_W | Frame receiving a new page |
| inst_page | input | PAGE_W | Page number being installed |
| fault_req | input | 1 | Start a victim search (ignored while busy) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse: victim reported |
| victim_frame | output | FRAME_W | Selected frame |
| victim_page | output | PAGE_W | Page resident in the selected frame |
| wb_valid | output | 1 | Write-back request valid |
| wb_ready | input | 1 | Write-back request accepted |
| wb_frame | output | FRAME_W | Frame to be written back |
| clean_valid | input | 1 | Write-back completed strobe |
| clean_frame | input | FRAME_W | Frame whose write-back completed |

## Verification
The search is driven from tables with no marks, with every frame marked, with a few scattered reads and writes ahead of the hand, and with every frame modified. The empty table and the scattered pattern separate stopping at the first eligible frame from sweeping too far; the all-marked table shows the wrap back to the starting frame; the all-modified table shows that each dirty frame is requested exactly once and that selection waits for a clean notification. A held-low `wb_ready` shows the hand stalling on a pending request, and an access timed onto the cycle the hand clears a mark shows the set winning, seen through which frame a later full sweep returns.

// File: rtl/cvs_pkg.sv
package cvs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SCAN   = 2'd1,
    ST_REPORT = 2'd2
  } sweep_state_t;
endpackage

// File: rtl/cvs_page_store.sv
module cvs_page_store #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 20,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cvs_flag_bank.sv
module cvs_flag_bank #(
  parameter int NUM_FRAMES = 16,
  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  acc_valid,
  input  logic [FRAME_W-1:0]    acc_frame,
  input  logic                  acc_write,
  input  logic                  inst_valid,
  input  logic [FRAME_W-1:0]    inst_frame,
  input  logic                  clean_valid,
  input  logic [FRAME_W-1:0]    clean_frame,
  input  logic                  clr_en,
  input  logic                  pend_set,
  input  logic [FRAME_W-1:0]    hand,
  output logic [NUM_FRAMES-1:0] mark_o,
  output logic [NUM_FRAMES-1:0] dirty_o,
  output logic [NUM_FRAMES-1:0] pend_o
);
  for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
    logic hit_acc, hit_inst, hit_clean, hit_hand;
    assign hit_acc   = acc_valid   && (acc_frame   == FRAME_W'(i));
    assign hit_inst  = inst_valid  && (inst_frame  == FRAME_W'(i));
    assign hit_clean = clean_valid && (clean_frame == FRAME_W'(i));
    assign hit_hand  = (hand == FRAME_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        mark_o[i]  <= 1'b0;
        dirty_o[i] <= 1'b0;
        pend_o[i]  <= 1'b0;
      end else begin
        // reference mark: a set beats the sweep's clear
        if (hit_acc || hit_inst)       mark_o[i] <= 1'b1;
        else if (clr_en && hit_hand)   mark_o[i] <= 1'b0;
        // modified flag: a fresh write beats any clear
        if (hit_acc && acc_write)      dirty_o[i] <= 1'b1;
        else if (hit_inst || hit_clean) dirty_o[i] <= 1'b0;
        // write-back outstanding
        if (hit_inst || hit_clean)     pend_o[i] <= 1'b0;
        else if (pend_set && hit_hand) pend_o[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cvs_sweep_ctrl.sv
module cvs_sweep_ctrl
  import cvs_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fault_req,
  input  logic [NUM_FRAMES-1:0] mark_i,
  input  logic [NUM_FRAMES-1:0] dirty_i,
  input  logic [NUM_FRAMES-1:0] pend_i,
  input  logic                  wb_ready,
  output logic [FRAME_W-1:0]    hand_o,
  output sweep_state_t          state_o,
  output logic                  clr_en_o,
  output logic                  pend_set_o,
  output logic                  wb_valid_o
);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);

  logic cur_mark, cur_dirty, cur_pend;
  logic scanning, pick, stall, advance;

  assign cur_mark  = mark_i[hand_o];
  assign cur_dirty = dirty_i[hand_o];
  assign cur_pend  = pend_i[hand_o];

  always_comb begin
    scanning   = (state_o == ST_SCAN);
    wb_valid_o = scanning && cur_dirty && !cur_pend;
    stall      = wb_valid_o && !wb_ready;
    pend_set_o = wb_valid_o && wb_ready;
    clr_en_o   = scanning;
    pick       = scanning && !cur_mark && !cur_dirty;
    advance    = scanning && !pick && !stall;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= ST_IDLE;
      hand_o  <= '0;
    end else begin
      if (advance) hand_o <= (hand_o == LAST_FRAME) ? '0 : hand_o + 1'b1;
      case (state_o)
        ST_IDLE:   if (fault_req) state_o <= ST_SCAN;
        ST_SCAN:   if (pick)      state_o <= ST_REPORT;
        ST_REPORT:                state_o <= ST_IDLE;
        default:                  state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
  import cvs_pkg::*;
#(
  parameter int NUM_FRAMES = 16,
  parameter int PAGE_W     = 20,
  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               acc_valid,
  input  logic [FRAME_W-1:0] acc_frame,
  input  logic               acc_write,
  input  logic               inst_valid,
  input  logic [FRAME_W-1:0] inst_frame,
  input  logic [PAGE_W-1:0]  inst_page,
  input  logic               fault_req,
  output logic               busy,
  output logic               done,
  output logic [FRAME_W-1:0] victim_frame,
  output logic [PAGE_W-1:0]  victim_page,
  output logic               wb_valid,
  input  logic               wb_ready,
  output logic [FRAME_W-1:0] wb_frame,
  input  logic               clean_valid,
  input  logic [FRAME_W-1:0] clean_frame
);
  logic [NUM_FRAMES-1:0] mark_w, dirty_w, pend_w;
  logic [FRAME_W-1:0]    hand_w;
  logic [PAGE_W-1:0]     page_rd;
  logic                  clr_en_w, pend_set_w;
  sweep_state_t          state_w;

  cvs_flag_bank #(.NUM_FRAMES(NUM_FRAMES)) u_flags (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
    .inst_valid(inst_valid), .inst_frame(inst_frame),
    .clean_valid(clean_valid), .clean_frame(clean_frame),
    .clr_en(clr_en_w), .pend_set(pend_set_w), .hand(hand_w),
    .mark_o(mark_w), .dirty_o(dirty_w), .pend_o(pend_w)
  );

  cvs_sweep_ctrl #(.NUM_FRAMES(NUM_FRAMES)) u_sweep (
    .clk(clk), .rst(rst), .fault_req(fault_req),
    .mark_i(mark_w), .dirty_i(dirty_w), .pend_i(pend_w),
    .wb_ready(wb_ready),
    .hand_o(hand_w), .state_o(state_w),
    .clr_en_o(clr_en_w), .pend_set_o(pend_set_w), .wb_valid_o(wb_valid)
  );

  cvs_page_store #(.DEPTH(NUM_FRAMES), .DATA_W(PAGE_W)) u_pages (
    .clk(clk),
    .wr_en(inst_valid), .wr_addr(inst_frame), .wr_data(inst_page),
    .rd_addr(hand_w), .rd_data(page_rd)
  );

  assign wb_frame = hand_w;
  assign busy     = (state_w != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      done         <= 1'b0;
      victim_frame <= '0;
      victim_page  <= '0;
    end else begin
      done <= (state_w == ST_REPORT);
      if (state_w == ST_REPORT) begin
        victim_frame <= hand_w;
        victim_page  <= page_rd;
      end
    end
  end
endmodule

// File: rtl/cvs_checker.sv
module cvs_checker #(
  parameter int NUM_FRAMES = 16,
  localparam int FRAME_W = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               fault_req,
  input logic               busy,
  input logic               done,
  input logic [FRAME_W-1:0] hand,
  input logic [FRAME_W-1:0] victim_frame,
  input logic               wb_valid,
  input logic               wb_ready,
  input logic [FRAME_W-1:0] wb_frame
);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(NUM_FRAMES - 1);

  // R4
  hand_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !fault_req) |=> $stable(hand));

  // R4
  hand_step_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> (hand == $past(hand)) ||
             (hand == (($past(hand) == LAST_FRAME) ? '0 : $past(hand) + 1'b1)));

  // R6
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_frame)));

  // R10
  wb_in_search_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_hand_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (victim_frame == hand && !wb_valid));
endmodule

bind clock_victim_sel cvs_checker #(.NUM_FRAMES(NUM_FRAMES)) u_cvs_checker (
  .clk(clk), .rst(rst), .fault_req(fault_req), .busy(busy), .done(done),
  .hand(hand_w), .victim_frame(victim_frame),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_frame(wb_frame)
);

// File: tb/clock_victim_sel_bench.sv
module clock_victim_sel_bench;
  localparam int N  = 16;
  localparam int FW = 4;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          acc_valid = 1'b0, acc_write = 1'b0;
  logic [FW-1:0] acc_frame = '0;
  logic          inst_valid = 1'b0;
  logic [FW-1:0] inst_frame = '0;
  logic [PW-1:0] inst_page = '0;
  logic          fault_req = 1'b0;
  logic          busy, done, wb_valid;
  logic [FW-1:0] victim_frame, wb_frame;
  logic [PW-1:0] victim_page;
  logic          wb_ready = 1'b1;
  logic          clean_valid = 1'b0;
  logic [FW-1:0] clean_frame = '0;

  int total = 0, bad = 0;
  int wb_cnt = 0, done_cnt = 0;
  logic [FW-1:0] wb_log [64];

  always #4 clk = ~clk;

  clock_victim_sel #(.NUM_FRAMES(N), .PAGE_W(PW)) u_clock_victim_sel (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
    .inst_valid(inst_valid), .inst_frame(inst_frame), .inst_page(inst_page),
    .fault_req(fault_req), .busy(busy), .done(done),
    .victim_frame(victim_frame), .victim_page(victim_page),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_frame(wb_frame),
    .clean_valid(clean_valid), .clean_frame(clean_frame)
  );

  // observe handshakes and done pulses between edges
  always @(negedge clk) begin
    if (!rst) begin
      if (wb_valid && wb_ready) begin
        if (wb_cnt < 64) wb_log[wb_cnt] = wb_frame;
        wb_cnt++;
      end
      if (done) done_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_install(input int f, input int p);
    inst_valid = 1'b1; inst_frame = FW'(f); inst_page = PW'(p);
    step();
    inst_valid = 1'b0;
  endtask

  task automatic do_access(input int f, input bit w);
    acc_valid = 1'b1; acc_frame = FW'(f); acc_write = w;
    step();
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic do_clean(input int f);
    clean_valid = 1'b1; clean_frame = FW'(f);
    step();
    clean_valid = 1'b0;
  endtask

  task automatic pulse_fault();
    fault_req = 1'b1;
    step();
    fault_req = 1'b0;
  endtask

  task automatic wait_done(input string req, input int exp_f, input int exp_p, input bit chk_page);
    bit seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(seen, {req, " done"}, int'(seen), 1);
    if (seen) begin
      check(victim_frame == FW'(exp_f), {req, " frame"}, int'(victim_frame), exp_f);
      if (chk_page)
        check(victim_page == PW'(exp_p), {req, " page"}, int'(victim_page), exp_p);
    end
    step();
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy && !done && !wb_valid, "R1 idle outputs", {busy, done, wb_valid}, 0);
    step();
    pulse_fault();
    wait_done("R1", 0, 0, 1'b0);
  endtask

  task automatic t_full_wrap();
    int base = wb_cnt;
    for (int f = 0; f < N; f++) do_install(f, 'h100 + f);
    pulse_fault();
    wait_done("R9", 0, 'h100, 1'b1);
    check(wb_cnt == base, "R3 installed clean", wb_cnt - base, 0);
  endtask

  task automatic t_reads();
    do_install(0, 'h200);
    do_access(1, 1'b0);
    do_access(2, 1'b0);
    pulse_fault();
    wait_done("R5", 3, 'h103, 1'b1);
  endtask

  task automatic t_writes();
    int base = wb_cnt;
    do_install(3, 'h203);
    do_access(4, 1'b1);
    do_access(5, 1'b1);
    pulse_fault();
    wait_done("R2", 6, 'h106, 1'b1);
    check(wb_cnt - base == 2, "R6 wb count", wb_cnt - base, 2);
    check(wb_log[base] == 4'd4, "R6 wb first", int'(wb_log[base]), 4);
    check(wb_log[base+1] == 4'd5, "R6 wb second", int'(wb_log[base+1]), 5);
    do_clean(4);
    do_clean(5);
  endtask

  task automatic t_backpressure();
    int base = wb_cnt;
    do_access(6, 1'b1);
    wb_ready = 1'b0;
    pulse_fault();
    repeat (5) step();
    @(negedge clk);
    check(wb_valid && wb_frame == 4'd6, "R6 held request", int'(wb_frame), 6);
    check(busy && wb_cnt == base, "R6 stalled", wb_cnt - base, 0);
    step();
    wb_ready = 1'b1;
    wait_done("R6", 7, 'h107, 1'b1);
    check(wb_cnt - base == 1, "R6 one accept", wb_cnt - base, 1);
    do_clean(6);
  endtask

  task automatic t_all_dirty();
    int base, dbase;
    for (int f = 0; f < N; f++) do_access(f, 1'b1);
    base = wb_cnt;
    dbase = done_cnt;
    pulse_fault();
    repeat (60) step();
    @(negedge clk);
    check(wb_cnt - base == N, "R6 each dirty once", wb_cnt - base, N);
    check(wb_log[base] == 4'd7, "R6 first from hand", int'(wb_log[base]), 7);
    check(wb_log[base+N-1] == 4'd6, "R4 wrap order", int'(wb_log[base+N-1]), 6);
    check(busy && done_cnt == dbase, "R10 keeps circling", done_cnt - dbase, 0);
    step();
    do_clean(9);
    wait_done("R7", 9, 'h109, 1'b1);
  endtask

  task automatic t_collision();
    int base = wb_cnt;
    for (int f = 0; f < N; f++) do_install(f, 'h300 + f);
    pulse_fault();
    wait_done("R3", 9, 'h309, 1'b1);
    check(wb_cnt == base, "R3 dirty cleared", wb_cnt - base, 0);
    do_install(9, 'h319);
    // fault sampled at next edge; access lands on the edge that clears frame 9
    fault_req = 1'b1;
    step();
    fault_req = 1'b0;
    acc_valid = 1'b1; acc_frame = 4'd9; acc_write = 1'b0;
    step();
    acc_valid = 1'b0;
    wait_done("R11 first", 10, 'h30A, 1'b1);
    for (int f = 0; f < N; f++) if (f != 9) do_install(f, 'h400 + f);
    pulse_fault();
    wait_done("R11", 10, 'h40A, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) step();
    rst = 1'b0;
    t_reset();
    t_full_wrap();
    t_reads();
    t_writes();
    t_backpressure();
    t_all_dirty();
    t_collision();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule